// File: doc/BRIEF.md
# One-Hot Word Bit-Index Unit (de Bruijn Multiply-and-Lookup)

This block takes a word that should carry exactly one set bit and returns the position of that bit. It does not search the word with a priority encoder. Instead it multiplies the word by a fixed constant. The constant is a cyclic binary sequence in which every window of LOG_W bits occurs exactly once. Because the input is a power of two, the multiply is only a left shift of the constant. The top LOG_W bits of the product, truncated to the word width, form a window that is unique for each bit position. A small table built at elaboration time maps each window back to its position.

The input side uses a valid/ready handshake. The output is a single registered stage with its own ready, and it carries the index and an invalid flag. A word with no bits set, or with more than one bit set, is still accepted. Its result has the invalid flag raised and index 0. A parameter selects how the constant is shifted: a true multiplier, or a select-and-OR of pre-shifted copies of the constant. Both give the same result for every input.

Top module: `dbj_log2`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid, out_index and out_invalid are all 0.
- R2: An accepted word with only bit i set (in_word = 1 << i, i in 0..2^LOG_W-1) produces out_index = i and out_invalid = 0.
- R3: An accepted all-zero word produces out_invalid = 1 and out_index = 0.
- R4: An accepted word with two or more bits set produces out_invalid = 1 and out_index = 0.
- R5: A word is accepted at a rising edge where in_valid and in_ready are both 1. Its result appears with out_valid = 1 right after that edge. If no word is accepted at an edge where the output was free, out_valid is 0 after that edge.
- R6: While out_valid = 1 and out_ready = 0, out_valid, out_index and out_invalid keep their values, and no new word is taken.
- R7: in_ready is 1 exactly when out_valid is 0 or out_ready is 1.
- R8: Both shift styles (MUL_STYLE = 0, multiplier; MUL_STYLE = 1, select-and-OR) give identical outputs for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 2^LOG_W | Word expected to hold a single set bit |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_valid | output | 1 | Result register holds a result |
| out_index | output | LOG_W | Position of the set bit, 0 when flagged |
| out_invalid | output | 1 | Input word had zero or several bits set |

## Verification
The assertions are checked on every cycle. They check that the lookup table inverts the shifted-constant window for every one-hot word presented to it. They also check that an accepted word always yields a valid result one edge later, that a stalled result does not change, that a word without exactly one bit set is always flagged, and that a flagged result carries index 0. Only the bench scenarios can show the rest. These are the full sweep of every bit position against an independent encoder, the handling of zero and dense words, and in_ready under random backpressure. They also show that the multiplier and select-and-OR variants agree cycle for cycle.

// File: rtl/dbj_pkg.sv
package dbj_pkg;

   // Largest supported window width and table stride.
   localparam int MAX_LOG_W = 6;
   localparam int STRIDE    = 6;
   localparam int TAB_BITS  = (1 << MAX_LOG_W) * STRIDE;

   // Cyclic sequence of 2^k bits in which each k-bit window appears once.
   // Greedy construction: start with k zeros, prefer appending a one.
   // The first sequence bit lands in the MSB of the 2^k-bit word.
   function automatic logic [63:0] dbj_seq(input int k);
      logic [63:0] s;
      logic [63:0] seen;
      int n;
      int win;
      int cand;
      n    = 1 << k;
      s    = '0;
      seen = '0;
      seen[0] = 1'b1;
      win  = 0;
      for (int pos = k; pos < n; pos++) begin
         cand = ((win << 1) | 1) & (n - 1);
         if (!seen[cand]) begin
            win = cand;
            s[n - 1 - pos] = 1'b1;
         end else begin
            win = (win << 1) & (n - 1);
         end
         seen[win] = 1'b1;
      end
      return s;
   endfunction

   // Inverse table: slot[window of (seq << i)] = i, STRIDE bits per slot.
   function automatic logic [TAB_BITS-1:0] dbj_table(input int k);
      logic [TAB_BITS-1:0] t;
      logic [63:0] c;
      logic [63:0] p;
      int n;
      int w;
      n = 1 << k;
      t = '0;
      c = dbj_seq(k);
      for (int i = 0; i < n; i++) begin
         p = c << i;
         if (n < 64) p = p & ((64'd1 << n) - 64'd1);
         w = int'(p >> (n - k));
         t[w*STRIDE +: STRIDE] = STRIDE'(i);
      end
      return t;
   endfunction

endpackage

// File: rtl/dbj_window.sv
module dbj_window
   import dbj_pkg::*;
#(
   parameter int LOG_W     = 5,
   parameter int MUL_STYLE = 0
) (
   input  logic [(1<<LOG_W)-1:0] word,
   output logic [LOG_W-1:0]      win
);
   localparam int W = 1 << LOG_W;
   localparam logic [63:0]  SEQ64 = dbj_seq(LOG_W);
   localparam logic [W-1:0] SEQ   = SEQ64[W-1:0];

   logic [W-1:0] prod;

   generate
      if (MUL_STYLE == 0) begin : g_mul
         // Truncated product keeps the low W bits.
         assign prod = word * SEQ;
      end else begin : g_sel
         // Select-and-OR of pre-shifted constants; equals the product for one-hot words.
         always_comb begin
            prod = '0;
            for (int j = 0; j < W; j++) begin
               if (word[j]) prod = prod | (SEQ << j);
            end
         end
      end
   endgenerate

   assign win = prod[W-1 -: LOG_W];
endmodule

// File: rtl/dbj_lut.sv
module dbj_lut
   import dbj_pkg::*;
#(
   parameter int LOG_W = 5
) (
   input  logic [LOG_W-1:0] win,
   output logic [LOG_W-1:0] idx
);
   localparam logic [TAB_BITS-1:0] TAB = dbj_table(LOG_W);

   logic [9:0] base;

   always_comb begin
      base = 10'(win) * 10'(STRIDE);
      idx  = TAB[base +: LOG_W];
   end
endmodule

// File: rtl/dbj_onehot.sv
module dbj_onehot #(
   parameter int W = 32
) (
   input  logic [W-1:0] word,
   output logic         ok
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   // Nonzero, and clearing the lowest set bit leaves nothing.
   assign ok = (word != '0) && ((word & (word - ONE)) == '0);
endmodule

// File: rtl/dbj_log2.sv
module dbj_log2
   import dbj_pkg::*;
#(
   parameter int LOG_W     = 5,
   parameter int MUL_STYLE = 0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [(1<<LOG_W)-1:0] in_word,
   input  logic                  out_ready,
   output logic                  out_valid,
   output logic [LOG_W-1:0]      out_index,
   output logic                  out_invalid
);
   localparam int W = 1 << LOG_W;
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   generate
      if (LOG_W < 2 || LOG_W > MAX_LOG_W) begin : g_bad_width
         $error("dbj_log2: LOG_W must lie in 2..6");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
         $error("dbj_log2: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   logic [LOG_W-1:0] win;
   logic [LOG_W-1:0] lut_idx;
   logic             word_ok;

   dbj_window #(.LOG_W(LOG_W), .MUL_STYLE(MUL_STYLE)) u_win (
      .word (in_word),
      .win  (win)
   );

   dbj_lut #(.LOG_W(LOG_W)) u_lut (
      .win (win),
      .idx (lut_idx)
   );

   dbj_onehot #(.W(W)) u_chk (
      .word (in_word),
      .ok   (word_ok)
   );

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_index   <= '0;
         out_invalid <= 1'b0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_index   <= word_ok ? lut_idx : '0;
            out_invalid <= !word_ok;
         end
      end
   end

   // R2
   lut_inverse_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && word_ok) |-> (in_word == (ONE << lut_idx)));

   // R4
   bad_word_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && $countones(in_word) != 1) |=> out_invalid);

   // R3
   flag_zero_idx_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_invalid) |-> (out_index == '0));

   // R5
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_index) && $stable(out_invalid)));
endmodule

// File: tb/sim_dbj_log2.sv
module sim_dbj_log2;
   localparam int LOG_W = 5;
   localparam int W = 1 << LOG_W;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [W-1:0] in_word = '0;
   logic out_ready = 1'b1;
   logic in_ready, out_valid, out_invalid;
   logic [LOG_W-1:0] out_index;
   logic in_ready1, out_valid1, out_invalid1;
   logic [LOG_W-1:0] out_index1;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   dbj_log2 #(.LOG_W(LOG_W), .MUL_STYLE(0)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .out_ready(out_ready), .out_valid(out_valid),
      .out_index(out_index), .out_invalid(out_invalid));

   dbj_log2 #(.LOG_W(LOG_W), .MUL_STYLE(1)) u1 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready1),
      .in_word(in_word), .out_ready(out_ready), .out_valid(out_valid1),
      .out_index(out_index1), .out_invalid(out_invalid1));

   // Behavioural reference model
   logic m_v = 1'b0, m_inv = 1'b0, m_st = 1'b0;
   int   m_idx = 0;
   int   m_kind = 2;

   function automatic int popc(input logic [W-1:0] x);
      int c = 0;
      for (int b = 0; b < W; b++) if (x[b]) c++;
      return c;
   endfunction

   function automatic int low_pos(input logic [W-1:0] x);
      for (int b = 0; b < W; b++) if (x[b]) return b;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_v <= 1'b0; m_inv <= 1'b0; m_idx <= 0; m_st <= 1'b0;
      end else if (!m_v || out_ready) begin
         m_st <= 1'b0;
         m_v  <= in_valid;
         if (in_valid) begin
            if (popc(in_word) == 1) begin
               m_idx <= low_pos(in_word); m_inv <= 1'b0; m_kind <= 2;
            end else begin
               m_idx <= 0; m_inv <= 1'b1;
               m_kind <= (in_word == '0) ? 3 : 4;
            end
         end
      end else begin
         m_st <= 1'b1;
      end
   end

   function automatic string tag_of();
      if (m_st) return "R6";
      if (m_kind == 3) return "R3";
      if (m_kind == 4) return "R4";
      return "R2";
   endfunction

   task automatic chk(input string req, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare at the falling edge, before inputs change.
   task automatic compare_all();
      chk("R7", int'(in_ready), int'(!m_v || out_ready), "in_ready");
      chk(m_st ? "R6" : "R5", int'(out_valid), int'(m_v), "out_valid");
      if (m_v) begin
         chk(tag_of(), int'(out_index), m_idx, "out_index");
         chk(tag_of(), int'(out_invalid), int'(m_inv), "out_invalid");
      end
      chk("R8", int'(out_valid1), int'(out_valid), "variant out_valid");
      if (out_valid) begin
         chk("R8", int'(out_index1), int'(out_index), "variant out_index");
         chk("R8", int'(out_invalid1), int'(out_invalid), "variant out_invalid");
      end
   endtask

   task automatic step(input logic v, input logic [W-1:0] w, input logic r);
      @(negedge clk);
      compare_all();
      in_valid  = v;
      in_word   = w;
      out_ready = r;
   endtask

   logic [31:0] lfsr = 32'h1ACE_B00C;
   task automatic lfsr_next();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
   endtask

   initial begin
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk("R1", int'(out_valid), 0, "reset out_valid");
         chk("R1", int'(out_index), 0, "reset out_index");
         chk("R1", int'(out_invalid), 0, "reset out_invalid");
      end
      rst = 1'b0;
      @(negedge clk);
      chk("R1", int'(out_valid), 0, "post-reset out_valid");
      chk("R1", int'(in_ready), 1, "post-reset in_ready");

      // R2: every bit position
      for (int i = 0; i < W; i++) step(1'b1, W'(1) << i, 1'b1);
      // R5: bubbles
      step(1'b0, '0, 1'b1);
      step(1'b0, '1, 1'b1);
      // R3: zero word
      step(1'b1, '0, 1'b1);
      step(1'b1, W'(32'h0000_0010), 1'b1);
      step(1'b1, '0, 1'b1);
      // R4: dense words
      step(1'b1, W'(32'h0000_0003), 1'b1);
      step(1'b1, '1, 1'b1);
      step(1'b1, W'(32'h8000_0001), 1'b1);
      step(1'b1, W'(32'hA5A5_A5A5), 1'b1);
      step(1'b1, W'(32'h0000_0C00), 1'b1);
      // R6: stall with a held result, new word offered
      step(1'b1, W'(32'h0002_0000), 1'b0);
      step(1'b1, W'(32'h0000_0100), 1'b0);
      step(1'b1, W'(32'h0000_0100), 1'b0);
      step(1'b1, W'(32'h0000_0100), 1'b1);
      // Mixed traffic with random backpressure
      for (int n = 0; n < 400; n++) begin
         lfsr_next();
         step(lfsr[7] | lfsr[9], lfsr[3] ? (W'(1) << lfsr[14:10]) : W'(lfsr ^ {lfsr[15:0], lfsr[31:16]}),
              lfsr[5] | lfsr[11]);
      end
      // Drain
      repeat (4) step(1'b0, '0, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule